// File: doc/BRIEF.md
# Flash Array Mode Decoder

This block models a small byte-wide nonvolatile array that is driven directly by its raw strobe lines instead of through a controller. On every clock edge it decodes eight enable lines and a test-mode line into one of four operations: read, program, page erase or mass erase. It then applies that operation to the main array or to a separate information area, as chosen by an area-select input. Addressing is split into a row (the upper part of the byte address) and a column that picks one of 64 bytes inside that row.

The block models programming as a flash cell does: a program can only clear bits, so the new byte is the old byte ANDed with the input. Erasing returns bytes to all ones, either one row at a time or a whole area at once. A strobe pattern that is not a recognised mode raises a registered illegal flag and leaves both areas untouched. The same happens when a row lies outside the selected area. The read port is registered: a byte appears on the output one cycle after a valid read and then stays there.

Top module: `flash_mode_array`

## Requirements
- R1: Read is row-enable, column-enable, sense-enable and output-enable high with program, erase, mass-select and store-enable low and test-mode high; at the next clock edge dout_o takes the byte at (row, column) of the selected area.
- R2: dout_o keeps its value in every cycle that is not a valid, in-range read, including cycles with program, erase, standby or illegal patterns.
- R3: Program is row-enable, column-enable, program-enable and store-enable high with sense, output, erase and mass-select low and test-mode high; the addressed byte becomes its old value AND din_i.
- R4: Page erase is row-enable, erase-enable and store-enable high with column-enable, sense, output, program and mass-select low and test-mode high; all 64 bytes of the addressed row become FFh, the column input is ignored and other rows keep their contents.
- R5: Mass erase is the page-erase pattern with mass-select high; every byte of the selected area becomes FFh, the row input is ignored and the other area keeps its contents.
- R6: With info_sel_i = 1 every operation acts on the information area, and with info_sel_i = 0 on the main array; the two areas hold independent bytes.
- R7: Any of the four mode patterns presented with test-mode low sets illegal_o at the next edge and changes no byte.
- R8: Any strobe combination other than the four modes and standby (all eight enables low) sets illegal_o at the next edge and changes no byte; standby clears illegal_o.
- R9: A read, program or page erase whose row is not below the selected area's row count (MAIN_ROWS or INFO_ROWS, so any set unused upper row bit counts) sets illegal_o, changes no byte and does not update dout_o.
- R10: While rst is high dout_o is 00h and illegal_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_i | input | 10 | Row address (upper byte-address bits) |
| col_i | input | 6 | Byte within the row |
| din_i | input | 8 | Program data |
| row_en_i | input | 1 | Row enable |
| col_en_i | input | 1 | Column enable |
| sense_en_i | input | 1 | Sense amplifier enable |
| out_en_i | input | 1 | Output enable |
| erase_en_i | input | 1 | Erase select |
| mass_sel_i | input | 1 | Whole-area erase select |
| prog_en_i | input | 1 | Program select |
| store_en_i | input | 1 | Nonvolatile store enable |
| test_mode_i | input | 1 | Must be high for every mode |
| info_sel_i | input | 1 | 1 = information area, 0 = main array |
| dout_o | output | 8 | Registered read data |
| illegal_o | output | 1 | Registered illegal-combination flag |

## Verification
The bench programs distinct bytes and then reprograms the same byte with an overlapping mask, so that a plain write and a bitwise AND give different results. The erase patterns are applied to one row, and to one area, while a neighbouring row and the other area hold known non-FF values; this shows whether an erase reaches too far or not far enough. Near-miss strobe patterns, such as read with program added, erase without store or any mode with test-mode low, are each followed by a read-back of a programmed byte to show that nothing changed. Rows just past the area end, and rows with only an unused upper bit set, would alias onto row 0 if the range check were missing, so row 0 is read back after each of them.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_READ,
    OP_PROG,
    OP_PERASE,
    OP_MERASE,
    OP_BAD
  } fmd_op_e;

  typedef struct packed {
    logic row_en;
    logic col_en;
    logic sense_en;
    logic out_en;
    logic prog_en;
    logic erase_en;
    logic mass_sel;
    logic store_en;
    logic test_mode;
  } fmd_ctrl_t;

  // Strobe patterns, bit order row,col,sense,out,prog,erase,mass,store
  localparam logic [7:0] PAT_READ   = 8'b1111_0000;
  localparam logic [7:0] PAT_PROG   = 8'b1100_1001;
  localparam logic [7:0] PAT_PERASE = 8'b1000_0101;
  localparam logic [7:0] PAT_MERASE = 8'b1000_0111;
  localparam logic [7:0] PAT_IDLE   = 8'b0000_0000;

endpackage

// File: rtl/fmd_decoder.sv
module fmd_decoder
  import fmd_pkg::*;
(
  input  fmd_ctrl_t ctrl_i,
  output fmd_op_e   op_o
);

  logic [7:0] pat;
  assign pat = {ctrl_i.row_en, ctrl_i.col_en, ctrl_i.sense_en, ctrl_i.out_en,
                ctrl_i.prog_en, ctrl_i.erase_en, ctrl_i.mass_sel, ctrl_i.store_en};

  always_comb begin
    unique case (pat)
      PAT_IDLE:   op_o = OP_IDLE;
      PAT_READ:   op_o = ctrl_i.test_mode ? OP_READ   : OP_BAD;
      PAT_PROG:   op_o = ctrl_i.test_mode ? OP_PROG   : OP_BAD;
      PAT_PERASE: op_o = ctrl_i.test_mode ? OP_PERASE : OP_BAD;
      PAT_MERASE: op_o = ctrl_i.test_mode ? OP_MERASE : OP_BAD;
      default:    op_o = OP_BAD;
    endcase
  end

endmodule

// File: rtl/fmd_bank.sv
module fmd_bank #(
  parameter int ROWS  = 8,
  parameter int COL_W = 6,
  parameter int ROW_W = 10,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             prog_we_i,
  input  logic             row_clr_i,
  input  logic             all_clr_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    rd_o
);

  localparam int COLS   = 1 << COL_W;
  localparam int DEPTH  = ROWS * COLS;
  localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int AW     = $clog2(DEPTH);

  logic [DW-1:0]     mem [DEPTH];
  logic [RIDX_W-1:0] ridx;
  logic [AW-1:0]     base;
  logic [AW-1:0]     addr;

  // Out-of-range rows fold to row 0; the top blocks any effect of them.
  assign ridx = (row_i < ROW_W'(ROWS)) ? row_i[RIDX_W-1:0] : '0;
  assign base = AW'({ridx, {COL_W{1'b0}}});
  assign addr = base | AW'(col_i);

  always_ff @(posedge clk) begin
    if (all_clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (row_clr_i) begin
      for (int c = 0; c < COLS; c++) mem[base + AW'(c)] <= '1;
    end else if (prog_we_i) begin
      mem[addr] <= mem[addr] & din_i;
    end
  end

  assign rd_o = mem[addr];

endmodule

// File: rtl/flash_mode_array.sv
module flash_mode_array
  import fmd_pkg::*;
#(
  parameter int MAIN_ROWS = 8,
  parameter int INFO_ROWS = 1,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 6,
  parameter int DW        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DW-1:0]    din_i,
  input  logic             row_en_i,
  input  logic             col_en_i,
  input  logic             sense_en_i,
  input  logic             out_en_i,
  input  logic             erase_en_i,
  input  logic             mass_sel_i,
  input  logic             prog_en_i,
  input  logic             store_en_i,
  input  logic             test_mode_i,
  input  logic             info_sel_i,
  output logic [DW-1:0]    dout_o,
  output logic             illegal_o
);

  fmd_ctrl_t ctrl;
  fmd_op_e   op;
  logic      main_ok, info_ok, area_ok, mode_ok, go, bad;
  logic      do_prog, do_row_clr, do_all_clr;
  logic [DW-1:0] main_rd, info_rd, rd_data;

  assign ctrl = {row_en_i, col_en_i, sense_en_i, out_en_i, prog_en_i,
                 erase_en_i, mass_sel_i, store_en_i, test_mode_i};

  fmd_decoder dec_i (
    .ctrl_i (ctrl),
    .op_o   (op)
  );

  assign main_ok = row_i < ROW_W'(MAIN_ROWS);
  assign info_ok = row_i < ROW_W'(INFO_ROWS);
  assign area_ok = (op == OP_MERASE) || (info_sel_i ? info_ok : main_ok);
  assign mode_ok = op inside {OP_READ, OP_PROG, OP_PERASE, OP_MERASE};
  assign go      = mode_ok && area_ok;
  assign bad     = (op == OP_BAD) || (mode_ok && !area_ok);

  assign do_prog    = go && (op == OP_PROG);
  assign do_row_clr = go && (op == OP_PERASE);
  assign do_all_clr = go && (op == OP_MERASE);

  fmd_bank #(
    .ROWS (MAIN_ROWS), .COL_W (COL_W), .ROW_W (ROW_W), .DW (DW)
  ) main_bank_i (
    .clk       (clk),
    .prog_we_i (do_prog    && !info_sel_i),
    .row_clr_i (do_row_clr && !info_sel_i),
    .all_clr_i (do_all_clr && !info_sel_i),
    .row_i     (row_i),
    .col_i     (col_i),
    .din_i     (din_i),
    .rd_o      (main_rd)
  );

  fmd_bank #(
    .ROWS (INFO_ROWS), .COL_W (COL_W), .ROW_W (ROW_W), .DW (DW)
  ) info_bank_i (
    .clk       (clk),
    .prog_we_i (do_prog    && info_sel_i),
    .row_clr_i (do_row_clr && info_sel_i),
    .all_clr_i (do_all_clr && info_sel_i),
    .row_i     (row_i),
    .col_i     (col_i),
    .din_i     (din_i),
    .rd_o      (info_rd)
  );

  assign rd_data = info_sel_i ? info_rd : main_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= bad;
      if (go && (op == OP_READ)) dout_o <= rd_data;
    end
  end

endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
  parameter int MAIN_ROWS = 8,
  parameter int INFO_ROWS = 1,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 6,
  parameter int DW        = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [ROW_W-1:0] row_i,
  input logic [COL_W-1:0] col_i,
  input logic [DW-1:0]    din_i,
  input logic             row_en_i,
  input logic             col_en_i,
  input logic             sense_en_i,
  input logic             out_en_i,
  input logic             erase_en_i,
  input logic             mass_sel_i,
  input logic             prog_en_i,
  input logic             store_en_i,
  input logic             test_mode_i,
  input logic             info_sel_i,
  input logic [DW-1:0]    dout_o,
  input logic             illegal_o
);

  logic [7:0] pat;
  logic       is_mode, in_rng, rd_ok, pg_ok, pe_ok;
  logic       p_prog, p_erase, p_sel;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;
  logic [DW-1:0]    p_din;

  assign pat = {row_en_i, col_en_i, sense_en_i, out_en_i,
                prog_en_i, erase_en_i, mass_sel_i, store_en_i};
  assign is_mode = (pat == 8'hF0) || (pat == 8'hC9) || (pat == 8'h85) || (pat == 8'h87);
  assign in_rng  = info_sel_i ? (row_i < ROW_W'(INFO_ROWS)) : (row_i < ROW_W'(MAIN_ROWS));
  assign rd_ok   = (pat == 8'hF0) && test_mode_i && in_rng;
  assign pg_ok   = (pat == 8'hC9) && test_mode_i && in_rng;
  assign pe_ok   = (pat == 8'h85) && test_mode_i && in_rng;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_prog <= 1'b0; p_erase <= 1'b0; p_sel <= 1'b0;
      p_row <= '0; p_col <= '0; p_din <= '0;
    end else begin
      p_prog <= pg_ok; p_erase <= pe_ok; p_sel <= info_sel_i;
      p_row <= row_i; p_col <= col_i; p_din <= din_i;
    end
  end

  // R2
  a_r2_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |=> $stable(dout_o));

  // R3
  a_r3_prog_clears_only: assert property (@(posedge clk) disable iff (rst)
    (p_prog && rd_ok && row_i == p_row && col_i == p_col && info_sel_i == p_sel)
    |=> ((dout_o & ~$past(p_din)) == '0));

  // R4
  a_r4_erase_gives_ones: assert property (@(posedge clk) disable iff (rst)
    (p_erase && rd_ok && row_i == p_row && info_sel_i == p_sel) |=> (dout_o == '1));

  // R7
  a_r7_test_low_flagged: assert property (@(posedge clk) disable iff (rst)
    (is_mode && !test_mode_i) |=> illegal_o);

  // R8
  a_r8_standby_clean: assert property (@(posedge clk) disable iff (rst)
    (pat == 8'h00) |=> !illegal_o);

  // R9
  a_r9_range_flagged: assert property (@(posedge clk) disable iff (rst)
    (test_mode_i && !in_rng && (pat == 8'hF0 || pat == 8'hC9 || pat == 8'h85)) |=> illegal_o);

endmodule

bind flash_mode_array fmd_checker #(
  .MAIN_ROWS (MAIN_ROWS), .INFO_ROWS (INFO_ROWS),
  .ROW_W (ROW_W), .COL_W (COL_W), .DW (DW)
) chk_i (
  .clk (clk), .rst (rst), .row_i (row_i), .col_i (col_i), .din_i (din_i),
  .row_en_i (row_en_i), .col_en_i (col_en_i), .sense_en_i (sense_en_i),
  .out_en_i (out_en_i), .erase_en_i (erase_en_i), .mass_sel_i (mass_sel_i),
  .prog_en_i (prog_en_i), .store_en_i (store_en_i), .test_mode_i (test_mode_i),
  .info_sel_i (info_sel_i), .dout_o (dout_o), .illegal_o (illegal_o)
);

// File: tb/flash_mode_array_tb.sv
`timescale 1ns/1ps
module flash_mode_array_tb_top;

  localparam int MROWS = 8;
  localparam int IROWS = 1;

  // {row,col,sense,out,prog,erase,mass,store,test}
  localparam logic [8:0] C_IDLE   = 9'b0000_0000_0;
  localparam logic [8:0] C_READ   = 9'b1111_0000_1;
  localparam logic [8:0] C_PROG   = 9'b1100_1001_1;
  localparam logic [8:0] C_PERASE = 9'b1000_0101_1;
  localparam logic [8:0] C_MERASE = 9'b1000_0111_1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] row_a = '0;
  logic [5:0] col_a = '0;
  logic [7:0] din = '0;
  logic [8:0] ctl = '0;
  logic info_sel = 1'b0;
  logic [7:0] dout;
  logic illegal;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] mm [MROWS*64];
  logic [7:0] im [IROWS*64];

  always #2.5 clk = ~clk;

  flash_mode_array #(.MAIN_ROWS(MROWS), .INFO_ROWS(IROWS)) dut_i (
    .clk (clk), .rst (rst), .row_i (row_a), .col_i (col_a), .din_i (din),
    .row_en_i (ctl[8]), .col_en_i (ctl[7]), .sense_en_i (ctl[6]), .out_en_i (ctl[5]),
    .prog_en_i (ctl[4]), .erase_en_i (ctl[3]), .mass_sel_i (ctl[2]),
    .store_en_i (ctl[1]), .test_mode_i (ctl[0]), .info_sel_i (info_sel),
    .dout_o (dout), .illegal_o (illegal)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus, sampled 1 ns after the edge, then back to standby.
  task automatic drive(input logic [8:0] c, input logic sel, input logic [9:0] r,
                       input logic [5:0] cl, input logic [7:0] d);
    @(negedge clk);
    ctl = c; info_sel = sel; row_a = r; col_a = cl; din = d;
    @(posedge clk); #1;
    ctl = C_IDLE;
  endtask

  task automatic rd(input logic sel, input int r, input int cl, output logic [7:0] v);
    drive(C_READ, sel, 10'(r), 6'(cl), 8'h00);
    v = dout;
  endtask

  task automatic rd_chk(input logic sel, input int r, input int cl, input string tag);
    logic [7:0] v;
    logic [7:0] e;
    rd(sel, r, cl, v);
    e = sel ? im[r*64+cl] : mm[r*64+cl];
    chk(v === e, tag, v, e);
  endtask

  task automatic prog(input logic sel, input int r, input int cl, input logic [7:0] d);
    drive(C_PROG, sel, 10'(r), 6'(cl), d);
    if (sel) im[r*64+cl] &= d; else mm[r*64+cl] &= d;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(dout === 8'h00, "R10 dout in reset", dout, 8'h00);
    chk(illegal === 1'b0, "R10 illegal in reset", illegal, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_mass_erase_init;
    drive(C_MERASE, 1'b0, 10'h3FF, 6'd5, 8'h00);
    chk(illegal === 1'b0, "R5 mass erase ignores row", illegal, 0);
    drive(C_MERASE, 1'b1, 10'd0, 6'd0, 8'h00);
    foreach (mm[i]) mm[i] = 8'hFF;
    foreach (im[i]) im[i] = 8'hFF;
    rd_chk(1'b0, 0, 0, "R5 main erased");
    rd_chk(1'b0, MROWS-1, 63, "R5 main last byte erased");
    rd_chk(1'b1, 0, 63, "R5 info erased");
  endtask

  task automatic t_program;
    prog(1'b0, 3, 10, 8'h5A);
    rd_chk(1'b0, 3, 10, "R1 R3 read programmed byte");
    prog(1'b0, 3, 10, 8'h0F);
    rd_chk(1'b0, 3, 10, "R3 second program ANDs (0A)");
    prog(1'b0, 3, 10, 8'hFF);
    rd_chk(1'b0, 3, 10, "R3 program FF cannot set bits");
    prog(1'b0, 2, 1, 8'hC3);
    rd_chk(1'b0, 2, 1, "R1 second address");
  endtask

  task automatic t_hold;
    logic [7:0] v;
    rd(1'b0, 2, 1, v);
    repeat (3) @(posedge clk);
    #1;
    chk(dout === v, "R2 hold during standby", dout, v);
    prog(1'b0, 5, 7, 8'h11);
    chk(dout === v, "R2 hold during program", dout, v);
  endtask

  task automatic t_info;
    prog(1'b1, 0, 10, 8'h33);
    rd_chk(1'b1, 0, 10, "R6 info byte programmed");
    rd_chk(1'b0, 0, 10, "R6 main byte untouched by info program");
    prog(1'b0, 0, 20, 8'h44);
    rd_chk(1'b1, 0, 20, "R6 info byte untouched by main program");
  endtask

  task automatic t_page_erase;
    int bad;
    logic [7:0] v;
    prog(1'b0, 3, 0, 8'h00);
    prog(1'b0, 3, 63, 8'h00);
    drive(C_PERASE, 1'b0, 10'd3, 6'd40, 8'h00);
    for (int c = 0; c < 64; c++) mm[3*64+c] = 8'hFF;
    bad = 0;
    for (int c = 0; c < 64; c++) begin
      rd(1'b0, 3, c, v);
      if (v !== 8'hFF) bad++;
    end
    chk(bad == 0, "R4 whole row erased", bad, 0);
    rd_chk(1'b0, 2, 1, "R4 neighbour row kept");
    rd_chk(1'b0, 4, 0, "R4 upper neighbour kept");
  endtask

  task automatic t_mass_info;
    drive(C_MERASE, 1'b1, 10'd0, 6'd0, 8'h00);
    foreach (im[i]) im[i] = 8'hFF;
    rd_chk(1'b1, 0, 10, "R5 info area erased");
    rd_chk(1'b0, 2, 1, "R5 main kept after info erase");
  endtask

  task automatic t_test_low;
    drive(C_PROG & 9'h1FE, 1'b0, 10'd2, 6'd1, 8'h00);
    chk(illegal === 1'b1, "R7 program with test low flagged", illegal, 1);
    rd_chk(1'b0, 2, 1, "R7 byte unchanged");
    chk(illegal === 1'b0, "R8 valid read clears flag", illegal, 0);
    drive(C_PERASE & 9'h1FE, 1'b0, 10'd2, 6'd0, 8'h00);
    rd_chk(1'b0, 2, 1, "R7 row not erased with test low");
  endtask

  task automatic t_illegal;
    logic [7:0] v;
    rd(1'b0, 2, 1, v);
    drive(9'b1111_1001_1, 1'b0, 10'd2, 6'd1, 8'h00);
    chk(illegal === 1'b1, "R8 read plus program flagged", illegal, 1);
    chk(dout === v, "R2 dout held on illegal read", dout, v);
    drive(9'b1000_0100_1, 1'b0, 10'd2, 6'd0, 8'h00);
    chk(illegal === 1'b1, "R8 erase without store flagged", illegal, 1);
    drive(9'b1100_0101_1, 1'b0, 10'd2, 6'd0, 8'h00);
    chk(illegal === 1'b1, "R8 erase with column enable flagged", illegal, 1);
    rd_chk(1'b0, 2, 1, "R8 byte unchanged after illegal patterns");
    drive(C_IDLE, 1'b0, 10'd0, 6'd0, 8'h00);
    chk(illegal === 1'b0, "R8 standby not illegal", illegal, 0);
  endtask

  task automatic t_range;
    logic [7:0] v;
    drive(C_PROG, 1'b0, 10'(MROWS), 6'd4, 8'h00);
    chk(illegal === 1'b1, "R9 row past end flagged", illegal, 1);
    rd_chk(1'b0, 0, 4, "R9 row 0 not aliased");
    drive(C_PROG, 1'b0, 10'h200, 6'd4, 8'h00);
    chk(illegal === 1'b1, "R9 upper row bit flagged", illegal, 1);
    rd_chk(1'b0, 0, 4, "R9 row 0 not aliased by upper bit");
    drive(C_PROG, 1'b1, 10'd1, 6'd4, 8'h00);
    chk(illegal === 1'b1, "R9 info row past end flagged", illegal, 1);
    rd_chk(1'b1, 0, 4, "R9 info row 0 unchanged");
    drive(C_PERASE, 1'b0, 10'h208, 6'd0, 8'h00);
    rd_chk(1'b0, 0, 20, "R9 out-of-range page erase no effect");
    rd(1'b0, 2, 1, v);
    drive(C_READ, 1'b0, 10'd9, 6'd1, 8'h00);
    chk(illegal === 1'b1, "R9 out-of-range read flagged", illegal, 1);
    chk(dout === v, "R9 out-of-range read leaves dout", dout, v);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_mass_erase_init;
    t_program;
    t_hold;
    t_info;
    t_page_erase;
    t_mass_info;
    t_test_low;
    t_illegal;
    t_range;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule